// File: doc/BRIEF.md
# Descriptor Ring Position Tracker

This block keeps the position of a DMA engine inside a circular ring of descriptors, for either the receive or the transmit side. It holds the ring size in a length register. The register stores the negated count of descriptors, so a ring of N entries reads back as 65536 − N. Each advance pulse moves the current index forward by one. After the last entry, the index returns to zero and a one-cycle wrap flag is raised.

The length register can be loaded in two ways. An initialization path takes a plain descriptor count and negates it. A direct register write takes the negated value as software supplies it. The register is deliberately left out of every reset and of the stop command, so a configured ring size survives any restart.

A length change does not cut short the pass that is in progress. The position counter takes a private copy of the register on restart and at each wrap, so a new size applies from the next pass onward. The engine that consumes the index handles descriptor fetch, ownership and bus mastering.

Top module: `ring_tracker`

## Requirements
- R1: In the cycle after a clock edge that sees `rst`, `soft_rst` or `stop` high, `idx` is 0 and `wrap` is 0.
- R2: An advance while not restarting increments `idx` by one, unless it wraps. Without an advance, `idx` holds and `wrap` stays low.
- R3: For a ring of N entries, where N = 65536 − register value, the advance taken at index N−1 returns `idx` to 0. It also raises `wrap` for exactly that one following cycle.
- R4: With the register at 0xFFFF (one entry), `idx` stays 0 and `wrap` is high after every advance.
- R5: A pulse on `init_ld` stores the two's complement of `init_len` in the length register.
- R6: A pulse on `reg_wr` stores `reg_wdata[15:0]` in the length register and ignores bits 31:16. `len_rdata` returns the register in bits 15:0, with bits 31:16 reading as zero.
- R7: When `reg_wr` and `init_ld` are high in the same cycle, the direct write wins.
- R8: `rst`, `soft_rst` and `stop` leave the length register unchanged.
- R9: A new length takes effect only at the next wrap or restart, and `idx` continues through the current pass. A write in the same cycle as a wrapping advance is first used at the wrap after that one.
- R10: While `stop` is high, advances are ignored and `idx` stays 0. Counting resumes from 0 once `stop` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous hard reset, active high |
| soft_rst | input | 1 | Synchronous software reset of the position |
| stop | input | 1 | Holds the position at 0 while high |
| adv | input | 1 | Step to the next descriptor |
| reg_wr | input | 1 | Direct write strobe for the length register |
| reg_wdata | input | 32 | Write data; bits 15:0 are the negated length |
| init_ld | input | 1 | Load strobe from the initialization sequence |
| init_len | input | 16 | Plain descriptor count for initialization |
| idx | output | 16 | Current descriptor index |
| wrap | output | 1 | One-cycle pulse after the index returns to 0 |
| len_rdata | output | 32 | Readback of the length register |

## Verification
A length write and the advance that closes the ring can occur in the same cycle. The bench raises `reg_wr` together with `adv` exactly at index N−1 and then steps through two further passes. It checks that the pass immediately after the wrap still uses the old size and that the new size appears only at the wrap after that. A behavioural model compares `idx`, `wrap` and `len_rdata` on every clock, and a pseudo-random phase also drives write/init collisions, restarts and advances together.

// File: rtl/ring_pkg.sv
package ring_pkg;
    parameter int unsigned LEN_W  = 16;
    parameter int unsigned WORD_W = 32;
    localparam int unsigned RSV_W = WORD_W - LEN_W;

    typedef logic [LEN_W-1:0] ring_len_t;

    typedef struct packed {
        ring_len_t left;
        ring_len_t idx;
    } ring_pos_t;

    typedef enum logic [1:0] {
        ACT_HOLD,
        ACT_STEP,
        ACT_WRAP,
        ACT_RESTART
    } ring_act_e;

    function automatic ring_len_t count_to_neg(input ring_len_t n);
        return ~n + ring_len_t'(1);
    endfunction

    function automatic logic is_last(input ring_len_t left);
        return &left;
    endfunction
endpackage

// File: rtl/ring_len_reg.sv
module ring_len_reg
    import ring_pkg::*;
(
    input  logic              clk,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              init_ld,
    input  ring_len_t         init_len,
    output ring_len_t         len_q
);
    ring_len_t len_r;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            len_r <= wr_data[LEN_W-1:0];
        end else if (init_ld) begin
            len_r <= count_to_neg(init_len);
        end
    end

    assign len_q = len_r;
endmodule

// File: rtl/ring_pos_ctr.sv
module ring_pos_ctr
    import ring_pkg::*;
(
    input  logic      clk,
    input  logic      restart,
    input  logic      adv,
    input  ring_len_t len_q,
    output ring_len_t idx,
    output logic      wrap
);
    ring_pos_t pos_q, pos_d;
    ring_act_e act;
    logic      wrap_q;

    always_comb begin
        if (restart) begin
            act = ACT_RESTART;
        end else if (adv) begin
            act = is_last(pos_q.left) ? ACT_WRAP : ACT_STEP;
        end else begin
            act = ACT_HOLD;
        end
    end

    always_comb begin
        pos_d = pos_q;
        unique case (act)
            ACT_RESTART, ACT_WRAP: begin
                pos_d.left = len_q;
                pos_d.idx  = '0;
            end
            ACT_STEP: begin
                pos_d.left = pos_q.left + ring_len_t'(1);
                pos_d.idx  = pos_q.idx + ring_len_t'(1);
            end
            default: pos_d = pos_q;
        endcase
    end

    always_ff @(posedge clk) begin
        pos_q  <= pos_d;
        wrap_q <= (act == ACT_WRAP);
    end

    assign idx  = pos_q.idx;
    assign wrap = wrap_q;
endmodule

// File: rtl/ring_tracker.sv
module ring_tracker
    import ring_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              stop,
    input  logic              adv,
    input  logic              reg_wr,
    input  logic [WORD_W-1:0] reg_wdata,
    input  logic              init_ld,
    input  logic [LEN_W-1:0]  init_len,
    output logic [LEN_W-1:0]  idx,
    output logic              wrap,
    output logic [WORD_W-1:0] len_rdata
);
    ring_len_t len_q;
    logic      restart;

    assign restart = rst | soft_rst | stop;

    ring_len_reg u_len (
        .clk      (clk),
        .wr_en    (reg_wr),
        .wr_data  (reg_wdata),
        .init_ld  (init_ld),
        .init_len (init_len),
        .len_q    (len_q)
    );

    ring_pos_ctr u_pos (
        .clk     (clk),
        .restart (restart),
        .adv     (adv),
        .len_q   (len_q),
        .idx     (idx),
        .wrap    (wrap)
    );

    generate
        if (RSV_W > 0) begin : g_rsv
            assign len_rdata = {{RSV_W{1'b0}}, len_q};
        end else begin : g_full
            assign len_rdata = len_q;
        end
    endgenerate
endmodule

// File: rtl/ring_tracker_chk.sv
module ring_tracker_chk
    import ring_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              soft_rst,
    input logic              stop,
    input logic              adv,
    input logic              reg_wr,
    input logic [WORD_W-1:0] reg_wdata,
    input logic              init_ld,
    input logic [LEN_W-1:0]  idx,
    input logic              wrap,
    input logic [WORD_W-1:0] len_rdata
);
    p_restart_r1: assert property (@(posedge clk) disable iff (rst)
        (soft_rst || stop) |=> (idx == '0 && !wrap));

    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (adv && !soft_rst && !stop) |=> (wrap || idx == LEN_W'($past(idx) + 1'b1)));

    p_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (!adv && !soft_rst && !stop) |=> ($stable(idx) && !wrap));

    p_wrap_zero_r3: assert property (@(posedge clk) disable iff (rst)
        wrap |-> (idx == '0));

    p_write_r6: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> (len_rdata[LEN_W-1:0] == $past(reg_wdata[LEN_W-1:0])));

    p_len_keep_r8: assert property (@(posedge clk) disable iff (rst)
        (!reg_wr && !init_ld) |=> $stable(len_rdata));
endmodule

bind ring_tracker ring_tracker_chk u_chk (.*);

// File: tb/tb_ring_tracker.sv
`timescale 1ns/1ps
module tb_ring_tracker;
    logic        clk = 1'b0;
    logic        rst, soft_rst, stop, adv, reg_wr, init_ld;
    logic [31:0] reg_wdata;
    logic [15:0] init_len;
    logic [15:0] idx;
    logic        wrap;
    logic [31:0] len_rdata;

    int    total = 0;
    int    bad   = 0;
    string cur_req = "R1";

    logic [15:0] m_reg = '0;
    bit          m_known = 0;
    int          m_idx = 0;
    int          m_n = 1;
    bit          m_wrap = 0;

    always #2 clk = ~clk;

    ring_tracker dut (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .stop(stop), .adv(adv),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .init_ld(init_ld),
        .init_len(init_len), .idx(idx), .wrap(wrap), .len_rdata(len_rdata)
    );

    function automatic int ring_n(input logic [15:0] r);
        return (r == 16'h0) ? 65536 : 65536 - int'(r);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        logic [15:0] old_reg;
        @(posedge clk);
        old_reg = m_reg;
        if (rst || soft_rst || stop) begin
            m_idx = 0; m_wrap = 0; m_n = ring_n(old_reg);
        end else if (adv) begin
            if (m_idx + 1 >= m_n) begin
                m_idx = 0; m_wrap = 1; m_n = ring_n(old_reg);
            end else begin
                m_idx++; m_wrap = 0;
            end
        end else begin
            m_wrap = 0;
        end
        if (reg_wr) begin
            m_reg = reg_wdata[15:0]; m_known = 1;
        end else if (init_ld) begin
            m_reg = 16'(-int'(init_len)); m_known = 1;
        end
        @(negedge clk);
        chk(idx == 16'(m_idx), cur_req, "model idx", idx, m_idx);
        chk(wrap == m_wrap, cur_req, "model wrap", wrap, m_wrap);
        if (m_known)
            chk(len_rdata == {16'h0, m_reg}, cur_req, "model rdata", len_rdata, {16'h0, m_reg});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] saved;
        int unsigned lfsr;
        rst = 1; soft_rst = 0; stop = 0; adv = 0; reg_wr = 0; init_ld = 0;
        reg_wdata = '0; init_len = '0;
        step();
        init_ld = 1; init_len = 16'd5; step(); init_ld = 0;
        step(); step();
        chk(idx == 0 && wrap == 0, "R1", "reset idx/wrap", {idx, 3'b0, wrap}, 0);
        chk(len_rdata == 32'h0000_FFFB, "R5", "init load", len_rdata, 32'h0000_FFFB);
        rst = 0;

        cur_req = "R2"; adv = 1;
        repeat (4) step();
        chk(idx == 4, "R2", "idx after 4", idx, 4);
        cur_req = "R3"; step();
        chk(idx == 0 && wrap, "R3", "wrap at end", {idx, 3'b0, wrap}, 1);
        adv = 0; step();
        chk(wrap == 0, "R3", "wrap one cycle", wrap, 0);

        cur_req = "R9"; adv = 1; step(); step();
        reg_wr = 1; reg_wdata = 32'hABCD_FFFD; step(); reg_wr = 0;
        chk(len_rdata == 32'h0000_FFFD, "R6", "write upper ignored", len_rdata, 32'h0000_FFFD);
        step();
        chk(idx == 4, "R9", "no truncation", idx, 4);
        step(); step(); step(); step();
        chk(idx == 0 && wrap, "R9", "new len at wrap", {idx, 3'b0, wrap}, 1);
        step(); step();
        reg_wr = 1; reg_wdata = 32'h0000_FFFE; step(); reg_wr = 0;
        chk(wrap == 1, "R9", "wrap with write", wrap, 1);
        step(); step();
        chk(idx == 2, "R9", "same-cycle write deferred", idx, 2);
        step(); step(); step();
        chk(idx == 0 && wrap, "R9", "len2 wrap", {idx, 3'b0, wrap}, 1);
        adv = 0;

        cur_req = "R7";
        reg_wr = 1; reg_wdata = 32'h0000_FFF9; init_ld = 1; init_len = 16'd3; step();
        reg_wr = 0; init_ld = 0;
        chk(len_rdata == 32'h0000_FFF9, "R7", "write beats init", len_rdata, 32'h0000_FFF9);
        cur_req = "R5"; init_ld = 1; init_len = 16'd10; step(); init_ld = 0;
        chk(len_rdata == 32'h0000_FFF6, "R5", "init negation", len_rdata, 32'h0000_FFF6);

        cur_req = "R4";
        reg_wr = 1; reg_wdata = 32'hFFFF_FFFF; step(); reg_wr = 0;
        chk(len_rdata == 32'h0000_FFFF, "R6", "upper reads zero", len_rdata, 32'h0000_FFFF);
        soft_rst = 1; step(); soft_rst = 0;
        adv = 1;
        for (int i = 0; i < 4; i++) begin
            step();
            chk(idx == 0 && wrap, "R4", "single entry", {idx, 3'b0, wrap}, 1);
        end
        adv = 0;

        cur_req = "R8"; saved = len_rdata;
        rst = 1; step(); rst = 0;
        chk(len_rdata == saved, "R8", "after rst", len_rdata, saved);
        soft_rst = 1; step(); soft_rst = 0;
        chk(len_rdata == saved, "R8", "after soft_rst", len_rdata, saved);
        stop = 1; step(); stop = 0;
        chk(len_rdata == saved, "R8", "after stop", len_rdata, saved);

        cur_req = "R10";
        reg_wr = 1; reg_wdata = 32'h0000_FFFC; step(); reg_wr = 0;
        soft_rst = 1; step(); soft_rst = 0;
        adv = 1; step(); step();
        chk(idx == 2, "R10", "before stop", idx, 2);
        stop = 1;
        repeat (3) begin
            step();
            chk(idx == 0 && !wrap, "R10", "stopped", {idx, 3'b0, wrap}, 0);
        end
        stop = 0; step();
        chk(idx == 1, "R10", "resume", idx, 1);
        adv = 0;

        cur_req = "R2"; lfsr = 32'h1234_5678;
        for (int i = 0; i < 400; i++) begin
            lfsr = lfsr * 32'd1103515245 + 32'd12345;
            adv       = lfsr[16];
            reg_wr    = (lfsr[20:17] == 4'd0);
            reg_wdata = {lfsr[15:0], 16'(-int'(2 + lfsr[23:21]))};
            init_ld   = (lfsr[27:24] == 4'd1);
            init_len  = 16'(1 + lfsr[30:28]);
            soft_rst  = (lfsr[31:26] == 6'd0);
            step();
        end
        adv = 0; reg_wr = 0; init_ld = 0; soft_rst = 0;
        step();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule